// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of an SDRAM interface and owns the command bus from reset until the memory is usable. After reset is released it first holds the bus idle for a stabilization period. It then issues a precharge to every bank and two auto refreshes. Last, it loads the mode register with a word built from its configuration inputs. Every gap between these steps is a parameter counted in clock cycles, and NOPs fill the gaps.

Once the wait that follows the mode register load has run out, `ready` goes high and stays high. From then on the sequencer only drives NOP. Normal traffic logic can then take the bus. While reset is low the bus shows command inhibit (chip select high). Any later reset starts the whole sequence again from the beginning.

The mode word has a fixed layout on the address bus. The two top field bits and A12 are forced low, and the bank bits are zero during the load.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst_n` is low, `cs_n` is 1 (command inhibit) and `ready` is 0.
- R2: In the first T_STABLE cycles after reset release, counted from the cycle in which `rst_n` goes high as cycle 0, the command {cs_n,ras_n,cas_n,we_n} is NOP = 4'b0111 and `ready` is 0.
- R3: In cycle T_STABLE the sequencer issues PRECHARGE = 4'b0010 with addr = 13'h0400 (A10 high selects all banks, every other address bit 0). It is issued exactly once per sequence.
- R4: Exactly two AUTO REFRESH commands (4'b0001) are issued. The first comes in cycle T_STABLE+T_RP and the second in cycle T_STABLE+T_RP+T_RC.
- R5: LOAD MODE REGISTER (4'b0000) is issued in cycle T_STABLE+T_RP+2*T_RC. It is issued only after both refreshes.
- R6: During the mode load, addr[2:0]=burst_len, addr[3]=burst_seq, addr[6:4]=cas_lat, addr[8:7]=op_mode, addr[9]=wr_burst, addr[12:10]=0 and ba=0.
- R7: Every cycle of the sequence that is not one of the commands above carries NOP.
- R8: `ready` rises in cycle T_STABLE+T_RP+2*T_RC+T_MRD and then stays high until reset. While `ready` is high the command is NOP.
- R9: A reset asserted part-way through the sequence restarts it, and the timing of R2 to R8 holds again from the new release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_len | input | 3 | Burst length field of the mode word |
| burst_seq | input | 1 | Burst type field (sequential or interleaved) |
| cas_lat | input | 3 | CAS latency field |
| op_mode | input | 2 | Operating mode field |
| wr_burst | input | 1 | Write burst mode field |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | 13 | Address bus A12..A0 |
| ba | output | 2 | Bank select |
| ready | output | 1 | Sequence complete, bus free for other commands |

## Verification
The bench builds the block with T_STABLE=20, T_RP=3, T_RC=5 and T_MRD=2. With these values a whole sequence lasts 35 cycles, so every cycle of it can be checked against a computed timeline several times over. Because the gaps differ from one another, a swapped or misplaced wait shows up at a distinct cycle. The mode vectors include all-ones operating mode and mixed field values, which brings field placement and the forced-zero top bits within reach. One run is cut off after the first refresh and restarted from reset.

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int T_STABLE = 20000,
  parameter int T_RP     = 3,
  parameter int T_RC     = 10,
  parameter int T_MRD    = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  burst_len,
  input  logic        burst_seq,
  input  logic [2:0]  cas_lat,
  input  logic [1:0]  op_mode,
  input  logic        wr_burst,
  output logic        cs_n,
  output logic        ras_n,
  output logic        cas_n,
  output logic        we_n,
  output logic [12:0] addr,
  output logic [1:0]  ba,
  output logic        ready
);

  localparam int MAX_A = (T_STABLE > T_RP) ? T_STABLE : T_RP;
  localparam int MAX_B = (T_RC > T_MRD) ? T_RC : T_MRD;
  localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAX_T + 1);

  localparam logic [CW-1:0] LAST_STABLE = CW'(T_STABLE - 1);
  localparam logic [CW-1:0] LAST_RP     = CW'(T_RP - 1);
  localparam logic [CW-1:0] LAST_RC     = CW'(T_RC - 1);
  localparam logic [CW-1:0] LAST_MRD    = CW'(T_MRD - 1);

  localparam logic [3:0] C_INHIBIT = 4'b1111;
  localparam logic [3:0] C_NOP     = 4'b0111;
  localparam logic [3:0] C_PRE     = 4'b0010;
  localparam logic [3:0] C_REF     = 4'b0001;
  localparam logic [3:0] C_LMR     = 4'b0000;

  typedef enum logic [2:0] {
    PH_WAIT, PH_PRE, PH_REF1, PH_REF2, PH_LMR, PH_DONE
  } phase_t;

  phase_t          phase, phase_nx;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   cur_last, nx_last;
  logic            first;
  logic [3:0]      cmd;

  function automatic logic [CW-1:0] last_of(phase_t p);
    case (p)
      PH_WAIT:  return LAST_STABLE;
      PH_PRE:   return LAST_RP;
      PH_REF1:  return LAST_RC;
      PH_REF2:  return LAST_RC;
      PH_LMR:   return LAST_MRD;
      default:  return '0;
    endcase
  endfunction

  always_comb begin
    case (phase)
      PH_WAIT: phase_nx = PH_PRE;
      PH_PRE:  phase_nx = PH_REF1;
      PH_REF1: phase_nx = PH_REF2;
      PH_REF2: phase_nx = PH_LMR;
      default: phase_nx = PH_DONE;
    endcase
  end

  assign cur_last = last_of(phase);
  assign nx_last  = last_of(phase_nx);
  assign first    = (cnt == cur_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_WAIT;
      cnt   <= LAST_STABLE;
    end else if (phase != PH_DONE) begin
      if (cnt == '0) begin
        phase <= phase_nx;
        cnt   <= nx_last;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_comb begin
    cmd  = C_NOP;
    addr = '0;
    if (!rst_n) begin
      cmd = C_INHIBIT;
    end else if (first) begin
      case (phase)
        PH_PRE: begin
          cmd      = C_PRE;
          addr[10] = 1'b1;
        end
        PH_REF1, PH_REF2: cmd = C_REF;
        PH_LMR: begin
          cmd  = C_LMR;
          addr = {3'b000, wr_burst, op_mode, cas_lat, burst_seq, burst_len};
        end
        default: cmd = C_NOP;
      endcase
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign ba    = 2'b00;
  assign ready = rst_n && (phase == PH_DONE);

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        ras_n,
  input logic        cas_n,
  input logic        we_n,
  input logic [12:0] addr,
  input logic [1:0]  ba,
  input logic        ready
);
  logic [3:0] cmd;
  logic       pre_seen, lmr_seen;
  logic [1:0] ref_cnt;

  assign cmd = {cs_n, ras_n, cas_n, we_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_seen <= 1'b0;
      lmr_seen <= 1'b0;
      ref_cnt  <= 2'd0;
    end else begin
      if (cmd == 4'b0010) pre_seen <= 1'b1;
      if (cmd == 4'b0000) lmr_seen <= 1'b1;
      if (cmd == 4'b0001 && ref_cnt != 2'd3) ref_cnt <= ref_cnt + 2'd1;
    end
  end

  always_comb begin
    if (!rst_n) AST_RESET_INHIBIT: assert (cs_n && !ready); // R1
  end

  AST_SINGLE_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 4'b0010 |-> !pre_seen); // R3
  AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 4'b0010 |-> addr == 13'h0400); // R3
  AST_REF_AFTER_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 4'b0001 |-> pre_seen && ref_cnt < 2'd2); // R4
  AST_LOAD_AFTER_TWO_REF: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 4'b0000 |-> ref_cnt == 2'd2 && !lmr_seen); // R5
  AST_MODE_UPPER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 4'b0000 |-> addr[12:10] == 3'b000 && ba == 2'b00); // R6
  AST_READY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> lmr_seen); // R8
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready); // R8
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> cmd == 4'b0111); // R8
endmodule

bind sdram_init_seq sdram_init_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .addr(addr), .ba(ba), .ready(ready)
);

// File: tb/sdram_init_seq_test.sv
module sdram_init_seq_test;
  localparam int S = 20, RP = 3, RC = 5, MRD = 2;
  localparam int T_REF1 = S + RP;
  localparam int T_REF2 = S + RP + RC;
  localparam int T_LMR  = S + RP + 2 * RC;
  localparam int T_RDY  = T_LMR + MRD;
  localparam int RUN    = T_RDY + 6;

  // fields: burst_len(3) burst_seq(1) cas_lat(3) op_mode(2) wr_burst(1) expected word(13)
  localparam logic [22:0] VEC [4] = '{
    {3'b011, 1'b0, 3'b010, 2'b00, 1'b0, 13'h0023},
    {3'b010, 1'b1, 3'b011, 2'b00, 1'b1, 13'h023A},
    {3'b111, 1'b0, 3'b011, 2'b11, 1'b0, 13'h01B7},
    {3'b000, 1'b1, 3'b001, 2'b10, 1'b1, 13'h0318}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] burst_len = '0, cas_lat = '0;
  logic burst_seq = 1'b0, wr_burst = 1'b0;
  logic [1:0] op_mode = '0;
  logic cs_n, ras_n, cas_n, we_n, ready;
  logic [12:0] addr;
  logic [1:0] ba;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  sdram_init_seq #(.T_STABLE(S), .T_RP(RP), .T_RC(RC), .T_MRD(MRD)) uut (
    .clk(clk), .rst_n(rst_n), .burst_len(burst_len), .burst_seq(burst_seq),
    .cas_lat(cas_lat), .op_mode(op_mode), .wr_burst(wr_burst),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .ba(ba), .ready(ready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_cycle(input int i, input logic [12:0] word);
    logic [3:0] ecmd;
    string req;
    ecmd = 4'b0111;
    req  = (i < S) ? "R2" : (i >= T_RDY) ? "R8" : "R7";
    if (i == S)      begin ecmd = 4'b0010; req = "R3"; end
    if (i == T_REF1) begin ecmd = 4'b0001; req = "R4"; end
    if (i == T_REF2) begin ecmd = 4'b0001; req = "R4"; end
    if (i == T_LMR)  begin ecmd = 4'b0000; req = "R5"; end
    check(req, {28'd0, cs_n, ras_n, cas_n, we_n}, {28'd0, ecmd});
    check(i >= T_RDY ? "R8" : "R2", {31'd0, ready}, {31'd0, i >= T_RDY});
    if (i == S) check("R3", {19'd0, addr}, 32'h0400);
    if (i == T_LMR) check("R6", {17'd0, ba, addr}, {19'd0, word});
  endtask

  task automatic run_seq(input int stop_at, input logic [12:0] word);
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < stop_at; i++) begin
      if (i > 0) @(negedge clk);
      #1 check_cycle(i, word);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check("R1", {30'd0, cs_n, ready}, 32'h2);

    for (int v = 0; v < 4; v++) begin
      {burst_len, burst_seq, cas_lat, op_mode, wr_burst} = VEC[v][22:13];
      run_seq(RUN, VEC[v][12:0]);
      @(negedge clk) rst_n = 1'b0;
      #1 check("R1", {30'd0, cs_n, ready}, 32'h2);
      @(negedge clk);
    end

    // R9: reset after the first refresh, then a full sequence again
    {burst_len, burst_seq, cas_lat, op_mode, wr_burst} = VEC[2][22:13];
    run_seq(T_REF1 + 2, VEC[2][12:0]);
    @(negedge clk) rst_n = 1'b0;
    #1 check("R9", {30'd0, cs_n, ready}, 32'h2);
    run_seq(RUN, VEC[2][12:0]);
    check("R9", {31'd0, ready}, 32'h1);

    // R8: mode inputs changing after ready leave the bus at NOP with zero address
    {burst_len, burst_seq, cas_lat, op_mode, wr_burst} = 10'h3FF;
    @(negedge clk) #1;
    check("R8", {15'd0, cs_n, ras_n, cas_n, we_n, addr}, {15'd0, 4'b0111, 13'h0});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule